// File: doc/BRIEF.md
# Double-Buffered PWM Generator

A single-channel pulse-width modulator with a private counter. The counter moves one step on each tick of a clock enable that an external prescaler supplies. Software programs the period and the pulse width through four small registers. Each value goes first into a buffer register. The active copies load from the buffers only when a new period begins, so the output never glitches in the middle of a period.

The duty cycle covers the full range from 0% to 100%. The active level of the output is selectable. A sticky flag marks the start of every period and can drive an interrupt line. Software can read the live pin level. While the generator is stopped, the pin is a plain output bit that software sets directly.

Register map, selected by a 2-bit address:
- 0: period buffer.
- 1: width buffer.
- 2: control.
- 3: status.

Control fields:
- bit0: run.
- bit1: invert.
- bit2: interrupt enable.
- bit3: idle level.

Status fields:
- bit0: live pin level (read only).
- bit1: period flag (write 1 to clear).

Top module: `pwm_gen`

## Requirements
- R1: After reset, `pin_o` and `irq_o` are 0, and every register (address 0 to 3) reads 0.
- R2: While run (control bit0) is 1, the counter advances only on cycles where `tick_i` is 1. It wraps to 0 after max(P,1) ticks, where P is the active period. While `tick_i` is 0, the counter holds.
- R3: With invert (control bit1) at 0, `pin_o` is high while the count is below the active width W and low otherwise. W=0 keeps the pin low for the whole period.
- R4: An active width W greater than or equal to P keeps the pin active for the whole period.
- R5: Writes to the period buffer (address 0) and the width buffer (address 1) read back at once. They reach the output only at the next period start, and both load in the same cycle. While run is 0, the active values track the buffers.
- R6: The period flag (status bit1) becomes 1 on the cycle after each counter wrap. It also becomes 1 when run is written from 0 to 1. It stays at 1 until cleared.
- R7: Writing status with bit1=1 clears the flag. Writing bit1=0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_o` equals the flag ANDed with the interrupt enable (control bit2).
- R9: Invert=1 drives the active phase low and the inactive phase high.
- R10: Status bit0 always reads the current level of `pin_o`.
- R11: While run is 0, `pin_o` equals the idle level (control bit3) and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| pin_o | output | 1 | PWM or idle-level output |
| irq_o | output | 1 | Period-start interrupt request |

## Verification
The bench rewrites the buffers in the middle of a period. A design that loaded them at once would show a period or width change before the wrap.

It drives the two ends of the duty range:
- Width 0 must never produce a pulse.
- A width at or above the period must never drop.

It also drives the degenerate periods 0 and 1. An off-by-one compare or wrap would show there as a stray edge.

Flag clears are issued on every cycle across a wrap, so a clear that beat the set would leave the flag low. Sparse ticks expose a counter that runs on the raw clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    A_PER = 2'd0,
    A_WID = 2'd1,
    A_CTL = 2'd2,
    A_STS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic idle_lvl;
    logic irq_en;
    logic invert;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned FLAG_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         period_start_i,
  output logic [W-1:0] per_buf_o,
  output logic [W-1:0] wid_buf_o,
  output ctrl_t        ctrl_o,
  output logic         flag_o
);
  logic wr_per, wr_wid, wr_ctl, wr_sts, run_rise, flag_set, flag_clr;

  assign wr_per   = wr_en_i && (wr_addr_i == A_PER);
  assign wr_wid   = wr_en_i && (wr_addr_i == A_WID);
  assign wr_ctl   = wr_en_i && (wr_addr_i == A_CTL);
  assign wr_sts   = wr_en_i && (wr_addr_i == A_STS);
  assign run_rise = wr_ctl && wr_data_i[0] && !ctrl_o.run;
  assign flag_set = period_start_i || run_rise;
  assign flag_clr = wr_sts && wr_data_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_o <= '0;
      wid_buf_o <= '0;
      ctrl_o    <= '0;
      flag_o    <= 1'b0;
    end else begin
      if (wr_per) per_buf_o <= wr_data_i;
      if (wr_wid) wid_buf_o <= wr_data_i;
      if (wr_ctl) ctrl_o    <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      // set has priority over a simultaneous clear
      if (flag_set)      flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_buf_i,
  input  logic [W-1:0] wid_buf_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] act_per_o,
  output logic [W-1:0] act_wid_o,
  output logic         active_o,
  output logic         wrap_o
);
  logic [W-1:0] last_idx;

  assign last_idx = (act_per_o == '0) ? '0 : act_per_o - 1'b1;
  assign wrap_o   = run_i && tick_i && (cnt_o == last_idx);
  assign active_o = cnt_o < act_wid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      act_per_o <= '0;
      act_wid_o <= '0;
    end else if (!run_i || wrap_o) begin
      // stopped or period boundary: restart and take buffered values
      cnt_o     <= '0;
      act_per_o <= per_buf_i;
      act_wid_o <= wid_buf_i;
    end else if (tick_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         pin_o,
  output logic         irq_o
);
  logic [W-1:0] per_buf, wid_buf, cnt, act_per, act_wid;
  ctrl_t        ctrl;
  logic         flag, active, wrap;

  pwm_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_start_i(wrap),
    .per_buf_o(per_buf), .wid_buf_o(wid_buf), .ctrl_o(ctrl), .flag_o(flag)
  );

  pwm_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .run_i(ctrl.run), .tick_i,
    .per_buf_i(per_buf), .wid_buf_i(wid_buf),
    .cnt_o(cnt), .act_per_o(act_per), .act_wid_o(act_wid),
    .active_o(active), .wrap_o(wrap)
  );

  assign pin_o = ctrl.run ? (active ^ ctrl.invert) : ctrl.idle_lvl;
  assign irq_o = flag & ctrl.irq_en;

  always_comb begin
    unique case (rd_addr_i)
      A_PER:   rd_data_o = per_buf;
      A_WID:   rd_data_o = wid_buf;
      A_CTL:   rd_data_o = W'(ctrl);
      default: rd_data_o = W'({flag, pin_o});
    endcase
  end
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         pin_o,
  input logic         irq_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_per,
  input logic [W-1:0] act_wid,
  input logic         wrap,
  input logic         flag,
  input pwm_pkg::ctrl_t ctrl
);
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && !tick_i |=> $stable(cnt));

  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run |-> ((act_per == '0) ? (cnt == '0) : (cnt < act_per)));

  a_r3_zero_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && act_wid == '0 |-> pin_o == ctrl.invert);

  a_r4_full_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && act_per != '0 && act_wid >= act_per |-> pin_o != ctrl.invert);

  a_r5_active_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && !tick_i |=> $stable(act_per) && $stable(act_wid));

  a_r6_flag_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag);

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl.irq_en && flag);

  a_r11_idle_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |-> pin_o == ctrl.idle_lvl);
endmodule

bind pwm_gen pwm_gen_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .pin_o, .irq_o,
  .cnt, .act_per, .act_wid, .wrap, .flag, .ctrl
);

// File: tb/sim_pwm_gen.sv
`timescale 1ns/1ps
module sim_pwm_gen;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0;
  logic [1:0] wa = '0, ra = '0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] rd;
  logic pin, irq;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pb, m_wb, m_cnt, m_ap, m_aw;
  bit m_run, m_inv, m_ien, m_idle, m_flag;

  always #2 clk = ~clk;

  pwm_gen #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .pin_o(pin), .irq_o(irq)
  );

  function automatic bit m_pin();
    if (!m_run) return m_idle;
    return (m_cnt < m_aw) ^ m_inv;
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return m_pb;
      1: return m_wb;
      2: return {m_idle, m_ien, m_inv, m_run};
      default: return {m_flag, m_pin()};
    endcase
  endfunction

  task automatic model_step();
    int per;
    bit wrap, rise, clr;
    per  = (m_ap == 0) ? 1 : m_ap;
    wrap = m_run && tick && (m_cnt == per - 1);
    rise = we && wa == 2 && wd[0] && !m_run;
    clr  = we && wa == 3 && wd[1];
    if (!m_run || wrap) begin
      m_cnt = 0; m_ap = m_pb; m_aw = m_wb;
    end else if (tick) m_cnt++;
    if (wrap || rise) m_flag = 1;
    else if (clr) m_flag = 0;
    if (we) case (wa)
      0: m_pb = wd;
      1: m_wb = wd;
      2: begin m_run = wd[0]; m_inv = wd[1]; m_ien = wd[2]; m_idle = wd[3]; end
      default: ;
    endcase
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk("pin_o (R10 status mirror too)", pin, m_pin());
    chk("irq_o R8", irq, m_flag & m_ien);
    chk("rd_data", rd, m_rd(ra));
  endtask

  task automatic step(bit w, int a, int d, bit t);
    we = w; wa = a[1:0]; wd = d[W-1:0]; tick = t; ra = cyc[1:0];
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, int div);
    for (int i = 0; i < n; i++) step(0, 0, 0, (i % div) == 0);
  endtask

  task automatic wr(int a, int d);
    step(1, a, d, 1);
  endtask

  initial begin
    m_pb = 0; m_wb = 0; m_cnt = 0; m_ap = 0; m_aw = 0;
    m_run = 0; m_inv = 0; m_ien = 0; m_idle = 0; m_flag = 0;
    #1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values on all registers
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      ra = a[1:0]; #0.1;
      chk("reset readback", rd, 0);
    end
    chk("reset pin", pin, 0);
    chk("reset irq", irq, 0);
    // R11 idle level follows control bit3 while stopped
    cur_req = "R11";
    wr(2, 8); idle(4, 1);
    wr(2, 0); idle(3, 1);
    // R2 R3 basic PWM, tick every cycle then sparse
    cur_req = "R2";
    wr(0, 5); wr(1, 2); wr(2, 5); idle(16, 1);
    cur_req = "R3";
    idle(30, 3);
    // R5 buffer update mid-period
    cur_req = "R5";
    idle(2, 1); wr(0, 8); wr(1, 6); idle(20, 1);
    // R7 clears across a wrap, including set/clear collision
    cur_req = "R7";
    for (int i = 0; i < 10; i++) wr(3, 2);
    wr(3, 0); idle(3, 1);
    // R4 width at and beyond period
    cur_req = "R4";
    wr(0, 4); wr(1, 4); idle(12, 1);
    wr(1, 10); idle(12, 1);
    // R3 width zero
    cur_req = "R3";
    wr(1, 0); idle(12, 1);
    // R9 inverted polarity
    cur_req = "R9";
    wr(1, 1); wr(2, 7); idle(14, 2);
    // R2 degenerate periods 0 and 1
    cur_req = "R2";
    wr(0, 0); idle(8, 1);
    wr(0, 1); wr(1, 1); idle(8, 1);
    // R6 run restart sets flag, R8 gating off
    cur_req = "R6";
    wr(3, 2); wr(2, 0); wr(3, 2); idle(2, 1);
    wr(2, 1); idle(4, 1);
    cur_req = "R8";
    wr(0, 3); wr(1, 1); idle(10, 1); wr(2, 5); idle(6, 1);
    // R10 status bit0 tracks pin through several phases
    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 0, 1);
      ra = 2'd3; #0.1;
      chk("status bit0 vs pin", rd[0], pin);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule